// File: doc/BRIEF.md
# Software-Triggered Backplane Pulse Source

This block lets software fire and hold a set of shared trigger lines. A control write carries a line select, a protocol mode, a pulse bit that is active when written low, an interrupt enable and an interrupt clear. When the pulse bit is written low while the block is armed, the selected line gets one broadcast pulse. No receiver acknowledges the pulse. Writing the bit high again re-arms the block. A separate drive register holds any lines asserted at a steady level.

Every output is registered on the block clock, which is the 10 MHz reference. One clock of assertion is therefore 100 ns, which exceeds the 30 ns minimum width. One clock of deassertion is 100 ns, which exceeds the 50 ns minimum spacing. On the receive side, the incoming lines are brought into the clock domain through two flops. A rising edge on the currently selected line sets a sticky interrupt flag.

Top module: `trig_pulse_src`

## Requirements
- R1: After reset `trig_o` and `irq_o` are 0. The block starts armed, so a first write with the pulse bit at 0 produces a pulse with no prior re-arm.
- R2: A control write with `ctl_pulse_ni`=0 while armed, `ctl_mode_i`=2'b01 (synchronous) and `ctl_sel_i`<NUM_LINES drives a pulse on the selected line only. The pulse is high for exactly ASSERT_CYC clocks and starts on the second rising edge after the write edge.
- R3: After a request, further writes with the pulse bit at 0 produce nothing until a write with the pulse bit at 1 has re-armed the block.
- R4: Two pulses are always separated by at least GAP_CYC low clocks. A request accepted while a pulse or its gap is running is held and issued as soon as the gap ends. A re-arm is accepted while no request is waiting, or in the cycle that the waiting request starts.
- R5: A request whose `ctl_sel_i` is NUM_LINES or above produces no pulse.
- R6: A request with `ctl_mode_i` other than 2'b01 (2'b00 off, 2'b10 and 2'b11 reserved) produces no pulse.
- R7: A write to the drive register changes `trig_o` one clock after the write edge. The driven lines then stay asserted and are ORed with any pulse.
- R8: A rising edge on `trig_in_i` at the selected line sets a sticky flag on the third rising edge after the input changes. Edges on other lines leave the flag unchanged.
- R9: `irq_o` is the flag gated by the enable bit, which is written by every control write. Clearing the enable masks `irq_o` but keeps the flag.
- R10: A control write with `ctl_irq_clr_i`=1 clears the flag. If an edge arrives in the same cycle, the edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 10 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_sel_i | input | SEL_W | Line select |
| ctl_mode_i | input | 2 | Protocol mode, 2'b01 synchronous |
| ctl_pulse_ni | input | 1 | Pulse bit, 0 requests, 1 re-arms |
| ctl_irq_en_i | input | 1 | Interrupt enable |
| ctl_irq_clr_i | input | 1 | Clear interrupt flag |
| drv_we_i | input | 1 | Drive register write strobe |
| drv_data_i | input | NUM_LINES | Level drive bits |
| trig_in_i | input | NUM_LINES | Incoming trigger lines, asynchronous |
| trig_o | output | NUM_LINES | Trigger line outputs |
| irq_o | output | 1 | Trigger interrupt |

## Verification
The assertions assume that a control write always carries a complete set of fields, because select, mode and enable are all taken from the same strobe. They also assume that incoming lines are asynchronous and only ever seen after the two-flop stage. The bench therefore drives every field on every control write and changes inputs on the falling edge only. It holds each incoming line for several clocks, so the synchroniser never has to resolve a one-cycle glitch. Request sequences are paced so that re-arm writes fall either while no request waits or on the start cycle. This matches the acceptance rule that the pending checks rely on.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_SYNC = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    PG_IDLE = 2'b00,
    PG_HIGH = 2'b01,
    PG_GAP  = 2'b10
  } pg_state_e;
endpackage

// File: rtl/trig_req_ctl.sv
module trig_req_ctl
  import trig_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int SEL_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctl_we_i,
  input  logic [SEL_W-1:0]     ctl_sel_i,
  input  logic [1:0]           ctl_mode_i,
  input  logic                 ctl_pulse_ni,
  input  logic                 ctl_irq_en_i,
  input  logic                 drv_we_i,
  input  logic [NUM_LINES-1:0] drv_data_i,
  input  logic                 start_i,
  output logic                 pend_o,
  output logic [SEL_W-1:0]     pend_line_o,
  output logic [SEL_W-1:0]     sel_o,
  output logic                 irq_en_o,
  output logic [NUM_LINES-1:0] drv_o
);
  logic armed_q, pend_q;
  logic [SEL_W-1:0] line_q, sel_q;
  logic ie_q;
  logic [NUM_LINES-1:0] drv_q;
  logic sel_ok, fire, new_req, rearm;

  assign sel_ok  = int'(ctl_sel_i) < NUM_LINES;
  assign fire    = ctl_we_i && !ctl_pulse_ni && armed_q;
  assign new_req = fire && sel_ok && (ctl_mode_i == MODE_SYNC);
  // re-arm only when no request would be overwritten
  assign rearm   = ctl_we_i && ctl_pulse_ni && (!pend_q || start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
      line_q  <= '0;
      sel_q   <= '0;
      ie_q    <= 1'b0;
      drv_q   <= '0;
    end else begin
      if (ctl_we_i) begin
        sel_q <= ctl_sel_i;
        ie_q  <= ctl_irq_en_i;
      end
      if (rearm)     armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
      if (new_req) begin
        pend_q <= 1'b1;
        line_q <= ctl_sel_i;
      end else if (start_i) begin
        pend_q <= 1'b0;
      end
      if (drv_we_i) drv_q <= drv_data_i;
    end
  end

  assign pend_o      = pend_q;
  assign pend_line_o = line_q;
  assign sel_o       = sel_q;
  assign irq_en_o    = ie_q;
  assign drv_o       = drv_q;
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
  import trig_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int SEL_W      = 4,
  parameter int ASSERT_CYC = 1,
  parameter int GAP_CYC    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pend_i,
  input  logic [SEL_W-1:0]     pend_line_i,
  output logic                 start_o,
  output logic [NUM_LINES-1:0] pulse_o
);
  localparam int CNT_MAX = (ASSERT_CYC > GAP_CYC) ? ASSERT_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  pg_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] line_q;

  // a waiting request may start straight out of the last gap cycle
  assign start_o = pend_i && ((state_q == PG_IDLE) ||
                              (state_q == PG_GAP && cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PG_IDLE;
      cnt_q   <= '0;
      line_q  <= '0;
    end else if (start_o) begin
      state_q <= PG_HIGH;
      cnt_q   <= CNT_W'(ASSERT_CYC - 1);
      line_q  <= pend_line_i;
    end else begin
      unique case (state_q)
        PG_HIGH: begin
          if (cnt_q == '0) begin
            state_q <= PG_GAP;
            cnt_q   <= CNT_W'(GAP_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PG_GAP: begin
          if (cnt_q == '0) state_q <= PG_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign pulse_o[i] = (state_q == PG_HIGH) && (line_q == SEL_W'(i));
  end
endmodule

// File: rtl/trig_edge_irq.sv
module trig_edge_irq #(
  parameter int NUM_LINES = 8,
  parameter int SEL_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] trig_in_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 clr_i,
  input  logic                 irq_en_i,
  output logic                 flag_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] s1_q, s2_q, prev_q, rise;
  logic hit, flag_q;

  assign rise = s2_q & ~prev_q;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_LINES; i++)
      if (sel_i == SEL_W'(i)) hit = hit | rise[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      s1_q   <= trig_in_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (hit)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/trig_pulse_src.sv
module trig_pulse_src #(
  parameter int NUM_LINES  = 8,
  parameter int SEL_W      = 4,
  parameter int ASSERT_CYC = 1,
  parameter int GAP_CYC    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctl_we_i,
  input  logic [SEL_W-1:0]     ctl_sel_i,
  input  logic [1:0]           ctl_mode_i,
  input  logic                 ctl_pulse_ni,
  input  logic                 ctl_irq_en_i,
  input  logic                 ctl_irq_clr_i,
  input  logic                 drv_we_i,
  input  logic [NUM_LINES-1:0] drv_data_i,
  input  logic [NUM_LINES-1:0] trig_in_i,
  output logic [NUM_LINES-1:0] trig_o,
  output logic                 irq_o
);
  logic                 pend_q, start, ie_q, flag_q;
  logic [SEL_W-1:0]     pend_line, sel_q;
  logic [NUM_LINES-1:0] drv_q, pulse_vec, trig_q;

  trig_req_ctl #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_req (
    .clk_i, .rst_ni, .ctl_we_i, .ctl_sel_i, .ctl_mode_i, .ctl_pulse_ni,
    .ctl_irq_en_i, .drv_we_i, .drv_data_i,
    .start_i(start), .pend_o(pend_q), .pend_line_o(pend_line),
    .sel_o(sel_q), .irq_en_o(ie_q), .drv_o(drv_q)
  );

  trig_pulse_gen #(
    .NUM_LINES(NUM_LINES), .SEL_W(SEL_W),
    .ASSERT_CYC(ASSERT_CYC), .GAP_CYC(GAP_CYC)
  ) u_gen (
    .clk_i, .rst_ni, .pend_i(pend_q), .pend_line_i(pend_line),
    .start_o(start), .pulse_o(pulse_vec)
  );

  trig_edge_irq #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_irq (
    .clk_i, .rst_ni, .trig_in_i, .sel_i(sel_q),
    .clr_i(ctl_we_i && ctl_irq_clr_i), .irq_en_i(ie_q),
    .flag_o(flag_q), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= drv_q | pulse_vec;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/trig_pulse_src_chk.sv
module trig_pulse_src_chk
  import trig_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int SEL_W      = 4,
  parameter int ASSERT_CYC = 1,
  parameter int GAP_CYC    = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ctl_we_i,
  input logic                 ctl_pulse_ni,
  input logic [SEL_W-1:0]     ctl_sel_i,
  input logic [1:0]           ctl_mode_i,
  input logic                 ctl_irq_clr_i,
  input logic [NUM_LINES-1:0] pulse_vec,
  input logic [NUM_LINES-1:0] drv_q,
  input logic [NUM_LINES-1:0] trig_o,
  input logic                 pend_q,
  input logic                 start,
  input logic                 ie_q,
  input logic                 flag_q,
  input logic                 irq_o
);
  int   hi_cnt, lo_cnt;
  logic any_q;
  logic any_now;
  assign any_now = |pulse_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= 0;
      lo_cnt <= GAP_CYC;
      any_q  <= 1'b0;
    end else begin
      any_q <= any_now;
      if (any_now) begin
        hi_cnt <= any_q ? hi_cnt + 1 : 1;
        lo_cnt <= 0;
      end else if (lo_cnt < 1000) begin
        lo_cnt <= lo_cnt + 1;
      end
    end
  end

  p_pulse_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pulse_vec));

  p_min_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_q && !any_now) |-> hi_cnt >= ASSERT_CYC);

  p_min_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_q && any_now) |-> lo_cnt >= GAP_CYC);

  p_hold_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !start) |=> pend_q);

  p_bad_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !ctl_pulse_ni && int'(ctl_sel_i) >= NUM_LINES && !pend_q) |=> !pend_q);

  p_bad_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !ctl_pulse_ni && ctl_mode_i != MODE_SYNC && !pend_q) |=> !pend_q);

  p_drive_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(drv_q) & ~trig_o) == '0);

  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(ctl_we_i && ctl_irq_clr_i)) |=> flag_q);

  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_q || !flag_q) |-> !irq_o);
endmodule

bind trig_pulse_src trig_pulse_src_chk #(
  .NUM_LINES(NUM_LINES), .SEL_W(SEL_W),
  .ASSERT_CYC(ASSERT_CYC), .GAP_CYC(GAP_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_we_i(ctl_we_i),
  .ctl_pulse_ni(ctl_pulse_ni), .ctl_sel_i(ctl_sel_i), .ctl_mode_i(ctl_mode_i),
  .ctl_irq_clr_i(ctl_irq_clr_i), .pulse_vec(pulse_vec), .drv_q(drv_q),
  .trig_o(trig_o), .pend_q(pend_q), .start(start), .ie_q(ie_q),
  .flag_q(flag_q), .irq_o(irq_o)
);

// File: tb/sim_trig_pulse_src.sv
module sim_trig_pulse_src;
  localparam int N = 8;
  localparam logic [1:0] SYNC = 2'b01;

  typedef struct packed {
    logic [3:0] sel;
    logic [1:0] mode;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0,  2'b01, 8'h01},
    '{4'd3,  2'b01, 8'h08},
    '{4'd7,  2'b01, 8'h80},
    '{4'd8,  2'b01, 8'h00},
    '{4'd15, 2'b01, 8'h00},
    '{4'd2,  2'b00, 8'h00},
    '{4'd5,  2'b10, 8'h00},
    '{4'd6,  2'b11, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_pulse_n = 1'b1, ctl_ie = 1'b0, ctl_clr = 1'b0;
  logic [3:0] ctl_sel = '0;
  logic [1:0] ctl_mode = '0;
  logic drv_we = 1'b0;
  logic [N-1:0] drv_data = '0, trig_in = '0, trig;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [N-1:0] samp [1:5];

  always #5 clk = ~clk;

  trig_pulse_src u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_sel_i(ctl_sel),
    .ctl_mode_i(ctl_mode), .ctl_pulse_ni(ctl_pulse_n), .ctl_irq_en_i(ctl_ie),
    .ctl_irq_clr_i(ctl_clr), .drv_we_i(drv_we), .drv_data_i(drv_data),
    .trig_in_i(trig_in), .trig_o(trig), .irq_o(irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [3:0] s, input logic [1:0] m, input logic pn,
                           input logic ie, input logic clr);
    ctl_we = 1'b1; ctl_sel = s; ctl_mode = m; ctl_pulse_n = pn; ctl_ie = ie; ctl_clr = clr;
    step();
    ctl_we = 1'b0; ctl_clr = 1'b0;
  endtask

  task automatic drv_write(input logic [N-1:0] d);
    drv_we = 1'b1; drv_data = d;
    step();
    drv_we = 1'b0;
  endtask

  task automatic grab();
    for (int j = 1; j <= 5; j++) begin
      step();
      samp[j] = trig;
    end
  endtask

  function automatic logic others_zero();
    return samp[1] == '0 && samp[3] == '0 && samp[4] == '0 && samp[5] == '0;
  endfunction

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    chk(trig == '0, "R1 trig in reset", trig, 0);
    chk(irq == 1'b0, "R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    step();
    // R1: armed out of reset
    ctl_write(4'd0, SYNC, 1'b0, 1'b0, 1'b0);
    grab();
    chk(samp[2] == 8'h01, "R1 armed after reset", samp[2], 8'h01);

    // table walk: R2, R5, R6
    foreach (VECS[k]) begin
      ctl_write(VECS[k].sel, VECS[k].mode, 1'b1, 1'b0, 1'b0);
      step();
      ctl_write(VECS[k].sel, VECS[k].mode, 1'b0, 1'b0, 1'b0);
      grab();
      if (VECS[k].exp != '0)         tag = "R2 pulse";
      else if (VECS[k].mode != SYNC) tag = "R6 mode";
      else                           tag = "R5 select";
      chk(samp[2] == VECS[k].exp, tag, samp[2], VECS[k].exp);
      chk(others_zero(), "R2 single clock", {samp[1], samp[3], samp[4], samp[5]}, 0);
    end

    // R3: no re-arm, no pulse
    ctl_write(4'd1, SYNC, 1'b0, 1'b0, 1'b0);
    grab();
    chk(samp[2] == '0 && others_zero(), "R3 unarmed", samp[2], 0);
    ctl_write(4'd1, SYNC, 1'b1, 1'b0, 1'b0);
    step();
    ctl_write(4'd1, SYNC, 1'b0, 1'b0, 1'b0);
    grab();
    chk(samp[2] == 8'h02, "R3 rearmed", samp[2], 8'h02);

    // R4: request during pulse is held, one clock gap
    ctl_write(4'd2, SYNC, 1'b1, 1'b0, 1'b0);
    step();
    ctl_write(4'd2, SYNC, 1'b0, 1'b0, 1'b0);
    ctl_write(4'd2, SYNC, 1'b1, 1'b0, 1'b0);
    ctl_write(4'd2, SYNC, 1'b0, 1'b0, 1'b0);
    chk(trig == 8'h04, "R4 first pulse", trig, 8'h04);
    step();
    chk(trig == 8'h00, "R4 gap", trig, 0);
    step();
    chk(trig == 8'h04, "R4 held pulse", trig, 8'h04);
    step();
    chk(trig == 8'h00, "R4 end", trig, 0);

    // R7: level drive
    step();
    drv_write(8'h81);
    chk(trig == 8'h00, "R7 registered", trig, 0);
    step();
    chk(trig == 8'h81, "R7 drive", trig, 8'h81);
    ctl_write(4'd3, SYNC, 1'b1, 1'b0, 1'b0);
    step();
    ctl_write(4'd3, SYNC, 1'b0, 1'b0, 1'b0);
    grab();
    chk(samp[2] == 8'h89 && samp[4] == 8'h81, "R7 drive with pulse", samp[2], 8'h89);
    drv_write(8'h00);
    step();
    chk(trig == 8'h00, "R7 release", trig, 0);

    // R8: edge on selected line only
    ctl_write(4'd4, SYNC, 1'b1, 1'b1, 1'b1);
    trig_in = 8'h20;
    repeat (4) step();
    chk(irq == 1'b0, "R8 other line", irq, 0);
    trig_in = 8'h00;
    repeat (4) step();
    trig_in = 8'h10;
    step(); step();
    chk(irq == 1'b0, "R8 sync delay", irq, 0);
    step();
    chk(irq == 1'b1, "R8 edge sets flag", irq, 1);
    trig_in = 8'h00;
    repeat (3) step();
    chk(irq == 1'b1, "R8 sticky", irq, 1);

    // R9: enable masks, flag kept
    ctl_write(4'd4, SYNC, 1'b1, 1'b0, 1'b0);
    chk(irq == 1'b0, "R9 masked", irq, 0);
    ctl_write(4'd4, SYNC, 1'b1, 1'b1, 1'b0);
    chk(irq == 1'b1, "R9 flag kept", irq, 1);

    // R10: clear
    ctl_write(4'd4, SYNC, 1'b1, 1'b1, 1'b1);
    chk(irq == 1'b0, "R10 cleared", irq, 0);

    finish_run();
  end
endmodule